// File: doc/BRIEF.md
# QDR burst-of-four SRAM interface

A behaviour-level synchronous SRAM with a quad-data-rate port structure. Read data and write data travel on two dedicated buses, so a read and a write can be in progress in the same period and no bus ever turns around. A single address input serves both ports. Every location stores a line of four words, and a line always moves as a four-word burst, one word per half of the input clock period.

The block runs from one internal clock at twice the K rate. A two-bit phase counter stands in for the edges. Phase 0 and phase 2 are K-rise edges. Phase 1 and phase 3 are K#-rise edges. One command pair spans two K periods (four internal clocks). Both port selects and the read address are sampled on the phase-0 edge. The write address is sampled on the phase-2 edge. Write data follows in the next pair, and read data returns 2.5 K periods after its address.

Echo clocks run in step with the phase so that a receiver can capture read data. A valid flag marks exactly the beats that carry read words.

Top module: `qdr_b4_sram`

## Requirements
- R1: While reset is held and until the first pair starts, `rvalid` is 0, `rdata` is 0, `cq` is 0 and `cq_n` is 1.
- R2: From the first internal clock edge at which `cq` rises after reset release, `cq` inverts on every internal clock edge and `cq_n` is always its complement. Each rise of `cq` marks a phase-0 (pair-start K-rise) edge or a phase-2 edge, and the first rise is a phase-0 edge.
- R3: A read accepted on a phase-0 edge E (`rd_sel_n`=0, address on `addr`) drives word 0 of that line after edge E+5, which is 2.5 K periods later. Words 1, 2 and 3 follow after edges E+6, E+7 and E+8.
- R4: `rvalid` is 1 on exactly the beats that carry read words. At all other times `rvalid` is 0 and `rdata` is 0. Valid beats always come in runs of a multiple of four.
- R5: A write accepted on a phase-0 edge (`wr_sel_n`=0) takes its address on the following phase-2 edge. Its words 0 to 3 are taken from `wdata` on the phase-0, 1, 2 and 3 edges of the next pair, and word k is stored in slot k of the line.
- R6: When `wr_sel_n` is 1 at a phase-0 edge, the address and data presented for that write slot are ignored, and no location changes.
- R7: When `rd_sel_n` is 1 at a phase-0 edge, no read beats result: `rvalid` stays 0 for the four beats that a read would have used.
- R8: When both selects are 0 at the same phase-0 edge, both transactions take place. The read returns the line as it was before that same pair's write.
- R9: A read in the pair right after a write to the same address returns the newly written words, even though the write's last word has only just been accepted.
- R10: Reads accepted in consecutive pairs give an unbroken run of valid beats, with no gap between bursts.
- R11: Port selects and `addr` are sampled only on the edges named above. Values present on the other edges have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the K rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_sel_n | input | 1 | Read port select, active low, sampled on phase-0 edges |
| wr_sel_n | input | 1 | Write port select, active low, sampled on phase-0 edges |
| addr | input | ADDR_W | Shared address: read address at phase 0, write address at phase 2 |
| wdata | input | DATA_W | Write data word, one per internal clock edge |
| rdata | output | DATA_W | Read data word, one per internal clock edge |
| rvalid | output | 1 | High on beats that carry read data |
| cq | output | 1 | Echo clock, high after each K-rise edge |
| cq_n | output | 1 | Complementary echo clock |

## Verification
The checker watches these properties on every cycle:
- the echo clocks toggle and stay complementary;
- valid beats come in runs that are a multiple of four;
- `rdata` is zero outside valid beats;
- every accepted read raises `rvalid` exactly six clocks after its sampling edge, and every rise of `rvalid` traces back to such a read.

Only the bench scenarios can show that the words are correct and arrive in the right slot order. The same holds for the ordering of a read and a write in one pair, for read-after-write coherency in the next pair, and for deselected ports or off-edge inputs leaving the array untouched. The bench shows these by comparing against a reference array.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int BEATS = 4;
  typedef logic [1:0] phase_t;
  localparam phase_t PH_RD_K  = 2'd0;
  localparam phase_t PH_RD_KN = 2'd1;
  localparam phase_t PH_WR_K  = 2'd2;
  localparam phase_t PH_WR_KN = 2'd3;
endpackage

// File: rtl/qdr_rst_sync.sv
module qdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= 1'b1;
      s2 <= s1;
    end
  end

  assign rst_sync_n = s2;
endmodule

// File: rtl/qdr_phase.sv
module qdr_phase
  import qdr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t ph,
  output logic   cq,
  output logic   cq_n
);
  phase_t ph_nx;
  logic   cq_nx, cq_n_nx;

  always_comb begin
    ph_nx   = ph + phase_t'(1);
    cq_nx   = ~ph[0];
    cq_n_nx = ph[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_RD_K;
      cq   <= 1'b0;
      cq_n <= 1'b1;
    end else begin
      ph   <= ph_nx;
      cq   <= cq_nx;
      cq_n <= cq_n_nx;
    end
  end
endmodule

// File: rtl/qdr_wr_path.sv
module qdr_wr_path
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  phase_t                  ph,
  input  logic                    wr_sel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_waddr,
  output logic [BEATS*DATA_W-1:0] mem_wline
);
  logic              wr_req, nxt_vld, cur_vld;
  logic [ADDR_W-1:0] nxt_addr, cur_addr;
  logic [DATA_W-1:0] stage [BEATS-1];

  logic en_req, en_nxt, en_cur;

  always_comb begin
    en_req = (ph == PH_RD_K);
    en_nxt = (ph == PH_WR_K);
    en_cur = (ph == PH_WR_KN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_req  <= 1'b0;
      nxt_vld <= 1'b0;
      cur_vld <= 1'b0;
    end else begin
      if (en_req) wr_req  <= ~wr_sel_n;
      if (en_nxt) nxt_vld <= wr_req;
      if (en_cur) cur_vld <= nxt_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (en_nxt && wr_req)  nxt_addr <= addr;
    if (en_cur && nxt_vld) cur_addr <= nxt_addr;
  end

  for (genvar g = 0; g < BEATS - 1; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (cur_vld && ph == phase_t'(g)) stage[g] <= wdata;
    end
  end

  always_comb begin
    mem_we    = cur_vld && en_cur;
    mem_waddr = cur_addr;
    for (int k = 0; k < BEATS - 1; k++) mem_wline[k*DATA_W +: DATA_W] = stage[k];
    mem_wline[(BEATS-1)*DATA_W +: DATA_W] = wdata;
  end
endmodule

// File: rtl/qdr_rd_path.sv
module qdr_rd_path
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  phase_t                  ph,
  input  logic                    rd_sel_n,
  input  logic [ADDR_W-1:0]       addr,
  output logic [ADDR_W-1:0]       mem_raddr,
  input  logic [BEATS*DATA_W-1:0] mem_rline,
  output logic [DATA_W-1:0]       rdata,
  output logic                    rvalid
);
  logic                    rd_pend, burst_on;
  logic [ADDR_W-1:0]       raddr_q;
  logic [BEATS*DATA_W-1:0] rline;
  phase_t                  beat_idx;
  logic                    pair_edge;
  logic [DATA_W-1:0]       rdata_nx;
  logic                    rvalid_nx;

  always_comb begin
    pair_edge = (ph == PH_RD_K);
    beat_idx  = ph - phase_t'(1);
    rvalid_nx = burst_on;
    rdata_nx  = burst_on ? rline[int'(beat_idx)*DATA_W +: DATA_W] : '0;
    mem_raddr = raddr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend  <= 1'b0;
      burst_on <= 1'b0;
      rvalid   <= 1'b0;
      rdata    <= '0;
    end else begin
      if (pair_edge) begin
        rd_pend  <= ~rd_sel_n;
        burst_on <= rd_pend;
      end
      rvalid <= rvalid_nx;
      rdata  <= rdata_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (pair_edge && !rd_sel_n) raddr_q <= addr;
    if (pair_edge && rd_pend)   rline   <= mem_rline;
  end
endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              cq,
  output logic              cq_n
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LINE_W = BEATS * DATA_W;

  logic              rst_sync_n;
  phase_t            ph;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [LINE_W-1:0] mem_wline, mem_rline;
  logic [LINE_W-1:0] mem [DEPTH];

  qdr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  qdr_phase u_phase (.clk(clk), .rst_n(rst_sync_n), .ph(ph), .cq(cq), .cq_n(cq_n));

  qdr_wr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_sync_n), .ph(ph), .wr_sel_n(wr_sel_n), .addr(addr),
    .wdata(wdata), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wline(mem_wline)
  );

  qdr_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_sync_n), .ph(ph), .rd_sel_n(rd_sel_n), .addr(addr),
    .mem_raddr(mem_raddr), .mem_rline(mem_rline), .rdata(rdata), .rvalid(rvalid)
  );

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wline;
  end

  assign mem_rline = mem[mem_raddr];
endmodule

// File: rtl/qdr_b4_sram_chk.sv
module qdr_b4_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              irst_n,
  input logic [1:0]        ph,
  input logic              rd_sel_n,
  input logic              rvalid,
  input logic [DATA_W-1:0] rdata,
  input logic              cq,
  input logic              cq_n
);
  logic       up_q;
  logic [2:0] run_q;
  logic       rdacc;

  assign rdacc = (ph == 2'd0) && !rd_sel_n;

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      up_q  <= 1'b0;
      run_q <= 3'd0;
    end else begin
      up_q  <= 1'b1;
      run_q <= rvalid ? run_q + 3'd1 : 3'd0;
    end
  end

  // R2
  p_echo_toggle_r2: assert property (@(posedge clk) disable iff (!irst_n)
    up_q |-> (cq != $past(cq)));
  // R2
  p_echo_compl_r2: assert property (@(posedge clk) disable iff (!irst_n)
    cq_n == ~cq);
  // R3
  p_read_latency_r3: assert property (@(posedge clk) disable iff (!irst_n)
    rdacc |-> ##6 rvalid);
  // R3
  p_valid_origin_r3: assert property (@(posedge clk) disable iff (!irst_n)
    $rose(rvalid) |-> $past(rdacc, 6));
  // R4
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!irst_n)
    !rvalid |-> (rdata == '0));
  // R4
  p_burst_len_r4: assert property (@(posedge clk) disable iff (!irst_n)
    $fell(rvalid) |-> (run_q[1:0] == 2'd0));
endmodule

bind qdr_b4_sram qdr_b4_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .irst_n(rst_sync_n), .ph(ph), .rd_sel_n(rd_sel_n),
  .rvalid(rvalid), .rdata(rdata), .cq(cq), .cq_n(cq_n)
);

// File: tb/tb_qdr_b4_sram.sv
`timescale 1ns/1ps
module tb_qdr_b4_sram;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int NLOC = 1 << AW;

  logic          clk, rst_n, rd_sel_n, wr_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rvalid, cq, cq_n;

  qdr_b4_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .cq(cq), .cq_n(cq_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int unsigned n_chk = 0, n_bad = 0, cyc = 0;
  int unsigned btk = 0;
  bit          done = 0;

  logic [DW-1:0] ref_mem [NLOC][4];
  bit            exp_v [16];
  logic [DW-1:0] exp_d [16];
  string         exp_t [16];
  bit            pend_we = 0;
  logic [DW-1:0] pend_line [4];

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual 0x%0h expected 0x%0h", tag, cyc, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return DW'($urandom);
  endfunction

  task automatic step();
    int s;
    @(negedge clk);
    cyc++;
    btk = (btk + 1) % 4;
    s = cyc % 16;
    check("R2", {30'd0, cq, cq_n}, {30'd0, btk[0], ~btk[0]});
    check(exp_t[s], {13'd0, rvalid, rdata}, {13'd0, exp_v[s], exp_v[s] ? exp_d[s] : '0});
    exp_v[s] = 0;
    exp_d[s] = '0;
    exp_t[s] = "R4";
  endtask

  task automatic do_pair(bit re, int ra, bit we, int wa, string tag);
    for (int t = 0; t < 4; t++) begin
      step();
      if (t == 0) begin
        for (int k = 0; k < 4; k++) begin
          int s = (cyc + 6 + k) % 16;
          exp_v[s] = re;
          exp_d[s] = re ? ref_mem[ra][k] : '0;
          exp_t[s] = re ? tag : "R7";
        end
        rd_sel_n = ~re;
        wr_sel_n = ~we;
        addr     = AW'(ra);
      end else begin
        rd_sel_n = 1'($urandom);          // R11: off-edge values are ignored
        wr_sel_n = 1'($urandom);
        addr     = (t == 2) ? AW'(wa) : AW'($urandom);
      end
      wdata = pend_we ? pend_line[t] : rnd_word();
    end
    pend_we = we;
    if (we) begin
      for (int k = 0; k < 4; k++) begin
        pend_line[k]   = rnd_word();
        ref_mem[wa][k] = pend_line[k];
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 16; s++) begin
      exp_v[s] = 0;
      exp_d[s] = '0;
      exp_t[s] = "R4";
    end
    rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    check("R1", {30'd0, rvalid, cq}, 32'd0);
    check("R1", {14'd0, rdata}, 32'd0);
    check("R1", {31'd0, cq_n}, 32'd1);
    rst_n = 1'b1;
    @(posedge cq);
    btk = 0;
    step(); step(); step();
    // R5: fill every line, then read it back
    for (int a = 0; a < NLOC; a++) do_pair(0, 0, 1, a, "R5");
    for (int a = 0; a < NLOC; a++) do_pair(1, a, 0, 0, a < 24 ? "R3" : (a < 48 ? "R5" : "R10"));
    // R9: read right after write to same address
    do_pair(0, 0, 1, 5, "R9");
    do_pair(1, 5, 0, 0, "R9");
    // R8: read and write in the same pair
    do_pair(1, 5, 1, 5, "R8");
    do_pair(1, 5, 0, 0, "R8");
    // R6: deselected write with live address and data
    do_pair(0, 0, 0, 5, "R6");
    do_pair(1, 5, 0, 0, "R6");
    // R7: deselected reads
    do_pair(0, 5, 0, 0, "R7");
    do_pair(0, 9, 0, 0, "R7");
    do_pair(1, 9, 0, 0, "R11");
    for (int i = 0; i < 300; i++) begin
      bit re = ($urandom % 4) != 0;
      bit we = ($urandom % 2) != 0;
      int ra = $urandom % 8;
      int wa = $urandom % 8;
      do_pair(re, ra, we, wa, (re && we && ra == wa) ? "R8" : "R3");
    end
    for (int i = 0; i < 4; i++) do_pair(0, 0, 0, 0, "R7");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule